// File: doc/BRIEF.md
# Four-Phase Encoder Commutator

This block produces the four winding enables for a brushless DC or stepper motor. It follows the rotor through one electrical cycle with a ring counter. The ring counter moves on count strobes from a quadrature decoder, and each strobe carries a direction bit. Each encoder index mark re-zeroes the ring counter after the mark has been qualified, so any missed or extra counts are removed once per mark instead of adding up over time.

The electrical cycle is split into four equal quarters, and each phase owns one quarter. A programmable overlap widens every phase window on both sides, so neighbouring windings share conduction near the handover. A programmable advance moves all windows ahead of the measured rotor position, which helps at high speed.

While the inhibit input is high, the ring counter ignores the decoder and the index. An external step strobe then moves the counter by a quarter cycle per step, which drives the motor open loop. Current regulation and PWM belong to the next stage.

Top module: `phase_commutator`

## Requirements
- R1: While `rst_n` is low, `phase_en` is 4'b0000 from the first clock edge on. The ring count restarts at 0 when reset is released. With zero advance, the first output after reset is 4'b0001.
- R2: Each `cnt_strobe` with `cnt_dir`=1 raises the ring count by one, and with `cnt_dir`=0 lowers it by one. The count runs from 0 to `cfg_cycle`-1 and wraps in both directions.
- R3: With zero overlap, let q = `cfg_cycle`/4 and let e be the effective count. Bit k of `phase_en` is high exactly when k*q <= e < (k+1)*q, so exactly one bit is set.
- R4: A non-zero `cfg_overlap` v widens every window to [k*q - v, (k+1)*q + v), taken circularly over the cycle. Phase k is then active wherever its window covers e.
- R5: The effective count is (ring count + `cfg_advance`) mod `cfg_cycle`.
- R6: The ring counter is cleared when `index_n` goes from high to low and is then sampled low on three consecutive clock edges. A low lasting fewer than three edges has no effect, and a low that is held does not clear the counter again.
- R7: If a qualified index and a count strobe land in the same cycle, the index wins and the count becomes 0.
- R8: While `inhibit` is high, `cnt_strobe` and the index are ignored and the ring count holds.
- R9: While `inhibit` is high, each `step_strobe` moves the ring count by q, up if `step_dir`=1 and down if `step_dir`=0, modulo `cfg_cycle`.
- R10: While `inhibit` is low, `step_strobe` has no effect.
- R11: `phase_en` is registered. It shows the new ring count on the clock edge after the one that updated the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_strobe | input | 1 | One-cycle strobe for one decoded encoder count |
| cnt_dir | input | 1 | Direction of the count: 1 = up, 0 = down |
| index_n | input | 1 | Encoder index mark, active low |
| inhibit | input | 1 | High selects open-loop stepping and freezes encoder tracking |
| step_strobe | input | 1 | One-cycle open-loop step request |
| step_dir | input | 1 | Direction of the step: 1 = up, 0 = down |
| cfg_cycle | input | CNT_W | Counts per electrical cycle; a multiple of 4, at least 4 |
| cfg_overlap | input | CNT_W | Overlap counts added to each side of a window; less than cfg_cycle/4 |
| cfg_advance | input | CNT_W | Advance counts; less than cfg_cycle |
| phase_en | output | 4 | Winding enables; bit k drives phase k |

## Verification
Some properties are checked on every cycle:
- the ring count stays below the cycle length;
- the count holds when no strobe arrives, and holds while inhibited without a step;
- a qualified index leaves the count at zero;
- a qualified index lasts one cycle;
- exactly one phase is on when overlap is zero;
- the outputs are dark during reset.

Other behaviour can only be shown by the bench scenarios:
- the direction and wrap of counting;
- the exact window edges under overlap and advance;
- the filtering of short index lows;
- the precedence of the index over a count;
- quarter-cycle stepping.

In each case the bench compares the phase pattern against a position model held in the bench.

// File: rtl/comm_pkg.sv
// Package: shared constants and helpers for the four-phase commutator.
// Assumes every count value is below 2**CNT_W and the cycle length is at least 4.
package comm_pkg;
    localparam int NUM_PH = 4;

    // Circular add: (a + d) mod m, valid when a < m and d <= m.
    function automatic logic [31:0] mod_add(input logic [31:0] a, input logic [31:0] d,
                                            input logic [31:0] m);
        logic [31:0] s;
        s = a + d;
        return (s >= m) ? s - m : s;
    endfunction

    // Circular subtract: (a - d) mod m, valid when a < m and d <= m.
    function automatic logic [31:0] mod_sub(input logic [31:0] a, input logic [31:0] d,
                                            input logic [31:0] m);
        return (a >= d) ? a - d : a + m - d;
    endfunction
endpackage

// File: rtl/index_qualifier.sv
// Module: index_qualifier
// Emits a one-cycle pulse when the active-low index input has fallen from high
// and has then been sampled low on FILT consecutive edges. Lows shorter than
// FILT edges are dropped. A low that is held produces only one pulse.
// Assumes index_n is already synchronous to clk.
module index_qualifier #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic index_n,
    output logic idx_pulse
);
    localparam int HW = FILT + 1;

    logic [HW-1:0] hist;

    // Purpose: shift index samples into the history, newest in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[HW-2:0], index_n};
    end

    // Purpose: fire when the oldest sample was high and the FILT newest are low.
    always_comb begin
        idx_pulse = hist[HW-1] && (hist[HW-2:0] == '0);
    end

    AST_IDX_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        idx_pulse |=> !idx_pulse); // R6
endmodule

// File: rtl/ring_counter.sv
// Module: ring_counter
// Tracks rotor position within one electrical cycle. In tracking mode it
// follows the decoder count strobes, and a qualified index clears it with top
// priority. In inhibit mode it ignores both and moves by one quarter cycle per
// step strobe. Assumes cycle is a multiple of 4, at least 4, and static
// outside reset.
module ring_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cycle,
    input  logic [CNT_W-1:0] quarter,
    input  logic             cnt_strobe,
    input  logic             cnt_dir,
    input  logic             idx_pulse,
    input  logic             inhibit,
    input  logic             step_strobe,
    input  logic             step_dir,
    output logic [CNT_W-1:0] pos
);
    import comm_pkg::*;

    logic             move;
    logic             up;
    logic [CNT_W-1:0] delta;
    logic [CNT_W-1:0] pos_nx;

    // Purpose: choose the move source, size and direction for the current mode.
    always_comb begin
        move  = inhibit ? step_strobe : cnt_strobe;
        up    = inhibit ? step_dir    : cnt_dir;
        delta = inhibit ? quarter     : CNT_W'(1);
    end

    // Purpose: work out the next position; the index wins over any count.
    always_comb begin
        pos_nx = pos;
        if (idx_pulse && !inhibit)
            pos_nx = '0;
        else if (move && up)
            pos_nx = CNT_W'(mod_add(32'(pos), 32'(delta), 32'(cycle)));
        else if (move)
            pos_nx = CNT_W'(mod_sub(32'(pos), 32'(delta), 32'(cycle)));
    end

    // Purpose: hold the ring position register.
    always_ff @(posedge clk) begin
        if (!rst_n) pos <= '0;
        else        pos <= pos_nx;
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos < cycle); // R2
    AST_INDEX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        idx_pulse && !inhibit |=> pos == '0); // R6
    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit && !step_strobe |=> $stable(pos)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit && !cnt_strobe && !idx_pulse |=> $stable(pos)); // R10
endmodule

// File: rtl/phase_decoder.sv
// Module: phase_decoder
// Applies the advance to the ring position, then tests the result against the
// four quarter windows, each widened by the overlap. The enables are
// registered. Assumes advance < cycle and overlap < cycle/4.
module phase_decoder #(
    parameter int CNT_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CNT_W-1:0]           pos,
    input  logic [CNT_W-1:0]           cycle,
    input  logic [CNT_W-1:0]           quarter,
    input  logic [CNT_W-1:0]           overlap,
    input  logic [CNT_W-1:0]           advance,
    output logic [comm_pkg::NUM_PH-1:0] phase_en
);
    import comm_pkg::*;

    localparam int EW = CNT_W + 2;

    logic [EW-1:0]     eff;
    logic [NUM_PH-1:0] act;

    // Purpose: effective position = (pos + advance) mod cycle.
    always_comb begin
        eff = EW'(mod_add(32'(pos), 32'(advance), 32'(cycle)));
    end

    for (genvar k = 0; k < NUM_PH; k++) begin : g_win
        logic [EW-1:0] base;
        logic [EW-1:0] rel;
        // Purpose: distance of eff past this phase's window start, taken circularly.
        always_comb begin
            base = EW'(k) * EW'(quarter);
            rel  = EW'(mod_sub(32'(eff), 32'(base), 32'(cycle)));
        end
        assign act[k] = (rel < EW'(quarter) + EW'(overlap)) ||
                        (rel + EW'(overlap) >= EW'(cycle));
    end

    // Purpose: register the window decisions; dark during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_en <= '0;
        else        phase_en <= act;
    end

    AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(overlap) == '0) |-> $countones(phase_en) == 1); // R3
endmodule

// File: rtl/phase_commutator.sv
// Module: phase_commutator (top)
// Four-phase commutator. The index qualifier feeds the ring counter, and the
// ring counter feeds the phase window decoder. Assumes the configuration is a
// valid cycle (multiple of 4), overlap < cycle/4 and advance < cycle, and that
// it changes only while reset is held.
module phase_commutator #(
    parameter int CNT_W = 12,
    parameter int FILT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_strobe,
    input  logic             cnt_dir,
    input  logic             index_n,
    input  logic             inhibit,
    input  logic             step_strobe,
    input  logic             step_dir,
    input  logic [CNT_W-1:0] cfg_cycle,
    input  logic [CNT_W-1:0] cfg_overlap,
    input  logic [CNT_W-1:0] cfg_advance,
    output logic [3:0]       phase_en
);
    logic             idx_pulse;
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] pos;

    // Purpose: one phase window is a quarter of the electrical cycle.
    always_comb begin
        quarter = cfg_cycle >> 2;
    end

    index_qualifier #(.FILT(FILT)) u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .index_n   (index_n),
        .idx_pulse (idx_pulse)
    );

    ring_counter #(.CNT_W(CNT_W)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle       (cfg_cycle),
        .quarter     (quarter),
        .cnt_strobe  (cnt_strobe),
        .cnt_dir     (cnt_dir),
        .idx_pulse   (idx_pulse),
        .inhibit     (inhibit),
        .step_strobe (step_strobe),
        .step_dir    (step_dir),
        .pos         (pos)
    );

    phase_decoder #(.CNT_W(CNT_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos      (pos),
        .cycle    (cfg_cycle),
        .quarter  (quarter),
        .overlap  (cfg_overlap),
        .advance  (cfg_advance),
        .phase_en (phase_en)
    );

    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |=> phase_en == 4'b0000); // R1
endmodule

// File: tb/phase_commutator_tb.sv
`timescale 1ns/1ps
module phase_commutator_tb;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_strobe = 1'b0, cnt_dir = 1'b0, index_n = 1'b1;
    logic             inhibit = 1'b0, step_strobe = 1'b0, step_dir = 1'b0;
    logic [CNT_W-1:0] cfg_cycle = 12'd24, cfg_overlap = '0, cfg_advance = '0;
    logic [3:0]       phase_en;

    int n_chk = 0, n_bad = 0;
    int m_pos = 0, m_cyc = 24, m_ovl = 0, m_adv = 0;
    bit done = 0;

    always #2 clk = ~clk;

    phase_commutator #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_strobe(cnt_strobe), .cnt_dir(cnt_dir),
        .index_n(index_n), .inhibit(inhibit), .step_strobe(step_strobe),
        .step_dir(step_dir), .cfg_cycle(cfg_cycle), .cfg_overlap(cfg_overlap),
        .cfg_advance(cfg_advance), .phase_en(phase_en)
    );

    // Expected enables from the model position, following R3, R4 and R5.
    function automatic logic [3:0] exp_ph();
        logic [3:0] r;
        int q, e, rel;
        q = m_cyc / 4;
        e = (m_pos + m_adv) % m_cyc;
        for (int k = 0; k < 4; k++) begin
            rel = (e - k * q + m_cyc) % m_cyc;
            r[k] = (rel < q + m_ovl) || (rel >= m_cyc - m_ovl);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        n_chk++;
        if (phase_en !== exp) begin
            n_bad++;
            $display("FAIL %s: phase_en=%b expected=%b (model pos %0d)", req, phase_en, exp, m_pos);
        end
    endtask

    // Resets with a new configuration and checks the reset state (R1).
    task automatic do_reset(input int cyc, input int ovl, input int adv);
        @(negedge clk);
        rst_n = 1'b0; cnt_strobe = 0; step_strobe = 0; inhibit = 0; index_n = 1;
        cfg_cycle = CNT_W'(cyc); cfg_overlap = CNT_W'(ovl); cfg_advance = CNT_W'(adv);
        m_cyc = cyc; m_ovl = ovl; m_adv = adv; m_pos = 0;
        repeat (6) @(negedge clk);
        check("R1", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", exp_ph());
    endtask

    // One count strobe; the check lands two edges later (R11).
    task automatic cnt_pulse(input bit dir, input string req);
        cnt_strobe = 1'b1; cnt_dir = dir;
        @(negedge clk);
        cnt_strobe = 1'b0;
        if (!inhibit) m_pos = dir ? (m_pos + 1) % m_cyc : (m_pos + m_cyc - 1) % m_cyc;
        @(negedge clk);
        check(req, exp_ph());
    endtask

    task automatic step_pulse(input bit dir, input string req);
        step_strobe = 1'b1; step_dir = dir;
        @(negedge clk);
        step_strobe = 1'b0;
        if (inhibit) m_pos = dir ? (m_pos + m_cyc / 4) % m_cyc
                                 : (m_pos + m_cyc - m_cyc / 4) % m_cyc;
        @(negedge clk);
        check(req, exp_ph());
    endtask

    task automatic t_count_up_down();
        do_reset(24, 0, 0);
        for (int i = 0; i < 30; i++) cnt_pulse(1'b1, "R2/R3/R11 up");
        for (int i = 0; i < 40; i++) cnt_pulse(1'b0, "R2/R3 down wrap");
    endtask

    task automatic t_overlap();
        do_reset(24, 2, 0);
        for (int i = 0; i < 26; i++) cnt_pulse(1'b1, "R4 overlap");
        for (int i = 0; i < 5; i++) cnt_pulse(1'b0, "R4 overlap down");
    endtask

    task automatic t_advance();
        do_reset(24, 1, 5);
        for (int i = 0; i < 26; i++) cnt_pulse(1'b1, "R5 advance");
        do_reset(16, 0, 15);
        for (int i = 0; i < 18; i++) cnt_pulse(1'b0, "R5 advance down");
    endtask

    task automatic t_index();
        do_reset(24, 0, 0);
        for (int i = 0; i < 10; i++) cnt_pulse(1'b1, "R2 setup");
        index_n = 1'b0;
        repeat (5) @(negedge clk);
        m_pos = 0;
        check("R6 index clears", exp_ph());
        for (int i = 0; i < 8; i++) cnt_pulse(1'b1, "R6 held low no re-clear");
        index_n = 1'b1;
        repeat (4) @(negedge clk);
        index_n = 1'b0;
        repeat (2) @(negedge clk);
        index_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R6 short low ignored", exp_ph());
        // Index and a count strobe in the same cycle (R7).
        index_n = 1'b0;
        repeat (3) @(negedge clk);
        cnt_strobe = 1'b1; cnt_dir = 1'b1;
        @(negedge clk);
        cnt_strobe = 1'b0;
        @(negedge clk);
        m_pos = 0;
        check("R7 index beats count", exp_ph());
        index_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_inhibit();
        do_reset(24, 0, 0);
        for (int i = 0; i < 8; i++) cnt_pulse(1'b1, "R2 setup");
        inhibit = 1'b1;
        for (int i = 0; i < 5; i++) cnt_pulse(1'b0, "R8 count ignored");
        index_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 index ignored", exp_ph());
        index_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) step_pulse(1'b1, "R9 step up");
        for (int i = 0; i < 3; i++) step_pulse(1'b0, "R9 step down");
        inhibit = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step_pulse(1'b1, "R10 step ignored");
        cnt_pulse(1'b1, "R2 tracking resumes");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_count_up_down();
        t_overlap();
        t_advance();
        t_index();
        t_inhibit();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule